// File: doc/BRIEF.md
# Transmit Descriptor Write-Back Controller

This block sits inside a transmit DMA engine. It decides when finished transmit descriptors are reported back to host memory. Each completion arrives as a descriptor index plus a report-status flag. A descriptor with the flag clear is never reported on its own. A completion with the flag set arms an accumulator. When bursting is enabled, the accumulator then counts every later completion, flagged or not, up to a programmable write-back threshold. It then issues one burst request naming the first index and the number of descriptors covered. A flush input forces out any partial burst, for example when a queue is being disabled.

As an alternative, software can switch on head write-back. The enable is bit 0 of the low address word. In this mode no descriptor bodies are reported. Instead, each flagged completion produces a request to write that descriptor's index to a 64-bit address. The address is built from a high word and a 16-byte-aligned low word.

Top module: `txwb_ctrl`

## Requirements
- R1: After reset no request of either kind is pending or issued, head write-back is disabled, and the head address is zero.
- R2: A completion with the report-status flag clear, arriving while nothing is accumulated, produces no request and leaves nothing pending.
- R3: With bursting disabled, each flagged completion produces one burst request with count 1 and first index equal to that completion's index. The request is a one-cycle pulse in the cycle after the completion.
- R4: With bursting enabled and threshold N (1..16), a flagged completion starts accumulation with count 1. Each later completion adds 1, whatever its flag. When the count reaches N, one burst request carries the arming index and count N, and the accumulator empties.
- R5: A write-back threshold of 0 behaves as 1: each flagged completion is reported at once.
- R6: A threshold above 16 is treated as 16, so no burst covers more than 16 descriptors.
- R7: Flush emits the pending partial burst (arming index, current count) in the next cycle. Flush with nothing pending produces no request.
- R8: With head write-back on, a flagged completion produces a head request in the next cycle carrying its index and the configured address. Completions do not touch the burst accumulator, and unflagged completions produce nothing.
- R9: A write to the low address word takes bit 0 as the head write-back enable (1 on, 0 off). Its bits 3:0 are never stored, so the head address always ends in four zero bits. A write to the high word sets address bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_en | input | 1 | Enables burst accumulation of completions |
| cfg_wb_thresh | input | TH_W | Write-back threshold (0..16 meaningful, larger clamps) |
| cfg_lo_we | input | 1 | Write strobe for the low address word (bit 0 is head enable) |
| cfg_hi_we | input | 1 | Write strobe for the high address word |
| cfg_wdata | input | 32 | Configuration write data |
| cmp_valid | input | 1 | A descriptor completed this cycle |
| cmp_idx | input | IDX_W | Index of the completed descriptor |
| cmp_rs | input | 1 | Report-status flag of the completed descriptor |
| flush | input | 1 | Forces out a pending partial burst |
| burst_vld | output | 1 | Burst write-back request pulse |
| burst_first | output | IDX_W | First descriptor index of the burst |
| burst_cnt | output | CNT_W | Number of descriptors in the burst |
| head_vld | output | 1 | Head write-back request pulse |
| head_idx | output | IDX_W | Head index value to write |
| head_addr | output | 64 | Aligned target address of the head write |

## Verification
The bench checks that unflagged descriptors before arming are dropped. A design that counted them would emit bursts early or with the wrong first index. It checks that unflagged descriptors after arming are counted, where a wrong design would produce bursts that are too long. Threshold 0 and thresholds above 16 are driven to catch a design that hangs with zero limit or overflows its count. Flush is exercised with and without a pending burst. Head mode is checked with a low-word write whose bits 3:0 are all set, so a design that stored them shows a misaligned address.

// File: rtl/txwb_pkg.sv
package txwb_pkg;
    localparam int unsigned TXWB_IDX_W      = 10;
    localparam int unsigned TXWB_MAX_WTH    = 16;
    localparam int unsigned TXWB_TH_W       = 6;
    localparam int unsigned TXWB_ALIGN_BITS = 4;
endpackage

// File: rtl/txwb_cfg.sv
module txwb_cfg #(
    parameter int unsigned ALIGN_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo_we,
    input  logic        hi_we,
    input  logic [31:0] wdata,
    output logic        head_en,
    output logic [63:0] head_addr
);
    localparam int unsigned LO_W = 32 - ALIGN_BITS;

    typedef struct packed {
        logic            en;
        logic [LO_W-1:0] lo;
        logic [31:0]     hi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_low;

    assign unused_low = ^wdata[ALIGN_BITS-1:1];

    always_comb begin
        cfg_d = cfg_q;
        if (lo_we) begin
            cfg_d.en = wdata[0];
            cfg_d.lo = wdata[31:ALIGN_BITS];
        end
        if (hi_we) begin
            cfg_d.hi = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign head_en   = cfg_q.en;
    assign head_addr = {cfg_q.hi, cfg_q.lo, {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/txwb_accum.sv
module txwb_accum #(
    parameter int unsigned IDX_W   = 10,
    parameter int unsigned MAX_WTH = 16,
    parameter int unsigned TH_W    = 6,
    parameter int unsigned CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_en,
    input  logic [TH_W-1:0]  thresh,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    input  logic             rs,
    input  logic             flush,
    output logic             fire,
    output logic [IDX_W-1:0] fire_first,
    output logic [CNT_W-1:0] fire_cnt,
    output logic             armed
);
    typedef struct packed {
        logic             armed;
        logic [IDX_W-1:0] first;
        logic [CNT_W-1:0] count;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        if (!burst_en || thresh == '0)
            limit = CNT_W'(1);
        else if (thresh > TH_W'(MAX_WTH))
            limit = CNT_W'(MAX_WTH);
        else
            limit = thresh[CNT_W-1:0];
    end

    always_comb begin
        acc_d      = acc_q;
        fire       = 1'b0;
        fire_first = '0;
        fire_cnt   = '0;
        if (take) begin
            if (!acc_q.armed) begin
                if (rs) begin
                    acc_d.armed = 1'b1;
                    acc_d.first = idx;
                    acc_d.count = CNT_W'(1);
                end
            end else if (rs || burst_en) begin
                acc_d.count = acc_q.count + CNT_W'(1);
            end
        end
        if (acc_d.armed && (acc_d.count >= limit || flush)) begin
            fire        = 1'b1;
            fire_first  = acc_d.first;
            fire_cnt    = acc_d.count;
            acc_d.armed = 1'b0;
            acc_d.count = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign armed = acc_q.armed;
endmodule

// File: rtl/txwb_ctrl.sv
module txwb_ctrl
    import txwb_pkg::*;
#(
    parameter int unsigned IDX_W      = TXWB_IDX_W,
    parameter int unsigned MAX_WTH    = TXWB_MAX_WTH,
    parameter int unsigned TH_W       = TXWB_TH_W,
    parameter int unsigned ALIGN_BITS = TXWB_ALIGN_BITS,
    localparam int unsigned CNT_W     = $clog2(MAX_WTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_burst_en,
    input  logic [TH_W-1:0]  cfg_wb_thresh,
    input  logic             cfg_lo_we,
    input  logic             cfg_hi_we,
    input  logic [31:0]      cfg_wdata,
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_idx,
    input  logic             cmp_rs,
    input  logic             flush,
    output logic             burst_vld,
    output logic [IDX_W-1:0] burst_first,
    output logic [CNT_W-1:0] burst_cnt,
    output logic             head_vld,
    output logic [IDX_W-1:0] head_idx,
    output logic [63:0]      head_addr
);
    typedef struct packed {
        logic             bv;
        logic [IDX_W-1:0] bf;
        logic [CNT_W-1:0] bc;
        logic             hv;
        logic [IDX_W-1:0] hi;
        logic [63:0]      ha;
    } out_t;

    logic             head_en;
    logic [63:0]      cfg_addr;
    logic             acc_fire;
    logic [IDX_W-1:0] acc_first;
    logic [CNT_W-1:0] acc_cnt;
    logic             acc_armed;
    out_t             out_d, out_q;

    txwb_cfg #(.ALIGN_BITS(ALIGN_BITS)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_we     (cfg_lo_we),
        .hi_we     (cfg_hi_we),
        .wdata     (cfg_wdata),
        .head_en   (head_en),
        .head_addr (cfg_addr)
    );

    txwb_accum #(
        .IDX_W   (IDX_W),
        .MAX_WTH (MAX_WTH),
        .TH_W    (TH_W),
        .CNT_W   (CNT_W)
    ) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_en   (cfg_burst_en),
        .thresh     (cfg_wb_thresh),
        .take       (cmp_valid && !head_en),
        .idx        (cmp_idx),
        .rs         (cmp_rs),
        .flush      (flush),
        .fire       (acc_fire),
        .fire_first (acc_first),
        .fire_cnt   (acc_cnt),
        .armed      (acc_armed)
    );

    always_comb begin
        out_d    = out_q;
        out_d.bv = acc_fire;
        out_d.bf = acc_fire ? acc_first : '0;
        out_d.bc = acc_fire ? acc_cnt : '0;
        out_d.hv = cmp_valid && cmp_rs && head_en;
        out_d.hi = out_d.hv ? cmp_idx : '0;
        out_d.ha = cfg_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign burst_vld   = out_q.bv;
    assign burst_first = out_q.bf;
    assign burst_cnt   = out_q.bc;
    assign head_vld    = out_q.hv;
    assign head_idx    = out_q.hi;
    assign head_addr   = out_q.ha;
endmodule

// File: rtl/txwb_ctrl_chk.sv
module txwb_ctrl_chk #(
    parameter int unsigned IDX_W   = 10,
    parameter int unsigned MAX_WTH = 16,
    parameter int unsigned CNT_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_valid,
    input logic [IDX_W-1:0] cmp_idx,
    input logic             cmp_rs,
    input logic             flush,
    input logic             head_en,
    input logic             acc_armed,
    input logic             burst_vld,
    input logic [CNT_W-1:0] burst_cnt,
    input logic             head_vld,
    input logic [IDX_W-1:0] head_idx,
    input logic [63:0]      head_addr
);
    // R6
    burst_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_vld |-> (burst_cnt != '0 && burst_cnt <= CNT_W'(MAX_WTH)));

    // R9
    head_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_addr[3:0] == 4'b0000);

    // R8
    head_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_vld |-> $past(cmp_valid && cmp_rs && head_en));

    // R8
    head_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_vld |-> head_idx == $past(cmp_idx));

    // R7
    flush_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && acc_armed) |=> burst_vld);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!burst_vld && !head_vld));
endmodule

bind txwb_ctrl txwb_ctrl_chk #(
    .IDX_W   (IDX_W),
    .MAX_WTH (MAX_WTH),
    .CNT_W   (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_idx   (cmp_idx),
    .cmp_rs    (cmp_rs),
    .flush     (flush),
    .head_en   (head_en),
    .acc_armed (acc_armed),
    .burst_vld (burst_vld),
    .burst_cnt (burst_cnt),
    .head_vld  (head_vld),
    .head_idx  (head_idx),
    .head_addr (head_addr)
);

// File: tb/txwb_ctrl_tb_top.sv
module txwb_ctrl_tb_top;
    localparam int unsigned IDX_W = 10;
    localparam int unsigned TH_W  = 6;
    localparam int unsigned CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_burst_en = 1'b0;
    logic [TH_W-1:0]  cfg_wb_thresh = '0;
    logic             cfg_lo_we = 1'b0;
    logic             cfg_hi_we = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic             cmp_valid = 1'b0;
    logic [IDX_W-1:0] cmp_idx = '0;
    logic             cmp_rs = 1'b0;
    logic             flush = 1'b0;
    logic             burst_vld;
    logic [IDX_W-1:0] burst_first;
    logic [CNT_W-1:0] burst_cnt;
    logic             head_vld;
    logic [IDX_W-1:0] head_idx;
    logic [63:0]      head_addr;

    always #5 clk = ~clk;

    txwb_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_burst_en  (cfg_burst_en),
        .cfg_wb_thresh (cfg_wb_thresh),
        .cfg_lo_we     (cfg_lo_we),
        .cfg_hi_we     (cfg_hi_we),
        .cfg_wdata     (cfg_wdata),
        .cmp_valid     (cmp_valid),
        .cmp_idx       (cmp_idx),
        .cmp_rs        (cmp_rs),
        .flush         (flush),
        .burst_vld     (burst_vld),
        .burst_first   (burst_first),
        .burst_cnt     (burst_cnt),
        .head_vld      (head_vld),
        .head_idx      (head_idx),
        .head_addr     (head_addr)
    );

    typedef struct packed {
        logic             is_head;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic [63:0]      addr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    task automatic expect_burst(input int first, input int cnt, input string tag);
        exp_t e;
        e.is_head = 1'b0;
        e.idx     = IDX_W'(first);
        e.cnt     = CNT_W'(cnt);
        e.addr    = '0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic expect_head(input int idx, input logic [63:0] addr, input string tag);
        exp_t e;
        e.is_head = 1'b1;
        e.idx     = IDX_W'(idx);
        e.cnt     = '0;
        e.addr    = addr;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic complete(input int idx, input bit rs);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_idx   = IDX_W'(idx);
        cmp_rs    = rs;
        @(negedge clk);
        cmp_valid = 1'b0;
        cmp_rs    = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic write_cfg(input bit hi, input logic [31:0] data);
        @(negedge clk);
        cfg_lo_we = !hi;
        cfg_hi_we = hi;
        cfg_wdata = data;
        @(negedge clk);
        cfg_lo_we = 1'b0;
        cfg_hi_we = 1'b0;
    endtask

    // Monitor: pop and compare each request as it appears
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (burst_vld) begin
                n_cmp++;
                if (exp_q.size() == 0 || exp_q[0].is_head) begin
                    n_bad++;
                    $display("FAIL R2 unexpected burst: got first=%0d cnt=%0d, expected none",
                             burst_first, burst_cnt);
                end else begin
                    if (burst_first != exp_q[0].idx || burst_cnt != exp_q[0].cnt) begin
                        n_bad++;
                        $display("FAIL %s burst: got first=%0d cnt=%0d, expected first=%0d cnt=%0d",
                                 tag_q[0], burst_first, burst_cnt, exp_q[0].idx, exp_q[0].cnt);
                    end
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
            if (head_vld) begin
                n_cmp++;
                if (exp_q.size() == 0 || !exp_q[0].is_head) begin
                    n_bad++;
                    $display("FAIL R8 unexpected head write: got idx=%0d addr=%h, expected none",
                             head_idx, head_addr);
                end else begin
                    if (head_idx != exp_q[0].idx || head_addr != exp_q[0].addr) begin
                        n_bad++;
                        $display("FAIL %s head: got idx=%0d addr=%h, expected idx=%0d addr=%h",
                                 tag_q[0], head_idx, head_addr, exp_q[0].idx, exp_q[0].addr);
                    end
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        n_cmp++;
        if (burst_vld || head_vld || head_addr != 64'd0) begin
            n_bad++;
            $display("FAIL R1 reset: got bv=%0b hv=%0b addr=%h, expected 0 0 0",
                     burst_vld, head_vld, head_addr);
        end

        // R1/R3: head disabled after reset, so a flagged completion is a burst
        expect_burst(3, 1, "R1");
        complete(3, 1'b1);

        // R2: unflagged ignored; R3: bursting off, each flagged reported alone
        cfg_wb_thresh = 6'd4;
        complete(5, 1'b0);
        expect_burst(6, 1, "R3");
        complete(6, 1'b1);
        expect_burst(7, 1, "R3");
        complete(7, 1'b1);

        // R4: bursting on, threshold 4, unflagged after arming counts
        cfg_burst_en = 1'b1;
        complete(10, 1'b0);
        complete(11, 1'b1);
        complete(12, 1'b0);
        complete(13, 1'b0);
        expect_burst(11, 4, "R4");
        complete(14, 1'b1);

        // R5: threshold 0 behaves as 1
        cfg_wb_thresh = 6'd0;
        expect_burst(20, 1, "R5");
        complete(20, 1'b1);
        complete(21, 1'b0);

        // R6: threshold 40 clamps to 16
        cfg_wb_thresh = 6'd40;
        complete(30, 1'b1);
        for (int k = 31; k < 45; k++) complete(k, k[0]);
        expect_burst(30, 16, "R6");
        complete(45, 1'b0);

        // R7: flush drains a partial burst, then flush on empty does nothing
        cfg_wb_thresh = 6'd8;
        complete(50, 1'b1);
        complete(51, 1'b0);
        complete(52, 1'b1);
        expect_burst(50, 3, "R7");
        do_flush();
        do_flush();

        // R9: address words, low bits 3:0 dropped; R8: head mode
        write_cfg(1'b1, 32'h1234_5678);
        write_cfg(1'b0, 32'hABCD_EF0F);
        expect_head(60, 64'h1234_5678_ABCD_EF00, "R8");
        complete(60, 1'b1);
        complete(61, 1'b0);
        expect_head(62, 64'h1234_5678_ABCD_EF00, "R9");
        complete(62, 1'b1);
        // R8: accumulator untouched in head mode, so flush yields nothing
        do_flush();

        // R9: bit 0 clear turns head mode off
        cfg_burst_en = 1'b0;
        write_cfg(1'b0, 32'h0000_0000);
        expect_burst(70, 1, "R9");
        complete(70, 1'b1);

        repeat (4) @(negedge clk);
        // R2/R7: every expected request arrived
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 pending expectations: got %0d left, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule